// File: doc/BRIEF.md
# Effective Address Generator

This block turns the address fields of a decoded load, store or branch into the 32-bit effective address. It is purely combinational, so the address appears in the same cycle as its operands. The base operand is either a general register value or a literal zero. The zero is chosen when the base register index is 0. The second addend is either a sign-extended 16-bit immediate or the value of an index register.

From the effective address and the operand length, the block also works out where each operand byte sits in memory. Bytes that run past the top of the 32-bit space fold over to address 0. A flag marks the operands that fold over. A separate flag reports a word-boundary alignment exception. That check applies equally to both byte orders, but little-endian string or multiple transfers are exempt from it.

The block has no states or transitions. It sits between operand read and address translation and holds no storage.

Top module: `eag_top`

## Requirements
- R1: With `addr_mode` = 0, `ea` equals the base operand plus `imm_offset` sign-extended from bit 15 to 32 bits. An offset of zero is legal.
- R2: With `addr_mode` = 1, `ea` equals the base operand plus `index_val`.
- R3: When `base_idx` is 0, the base operand is the constant zero and `base_val` has no effect on any output. For any other index, the base operand is `base_val`.
- R4: The addition is unsigned modulo 2^32, and any carry out of bit 31 is dropped.
- R5: All outputs are combinational functions of the current inputs and hold no state. They are valid in the same cycle as the inputs.
- R6: `len_code` selects the operand length as 1 << `len_code` bytes (0 = 1, 1 = 2, 2 = 4, 3 = 8). Byte lane i of `byte_addr` occupies bits [32*i+31 : 32*i]. For i below the length, the lane holds (`ea` + i) mod 2^32 and `byte_valid[i]` is 1. Other lanes hold 0 and have a valid bit of 0.
- R7: `wrap` is 1 exactly when the address of the last operand byte is numerically below `ea`.
- R8: For a big-endian access (`little_endian` = 0), `align_exc` is 1 exactly when the length is 4 or 8 and `ea[1:0]` is nonzero, whatever `str_mult` is.
- R9: A little-endian access that is not a string/multiple transfer raises `align_exc` under the same condition as the big-endian access.
- R10: A little-endian access with `str_mult` = 1 never raises `align_exc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_idx | input | 5 | Base register number; 0 selects a literal zero base |
| base_val | input | 32 | Contents of the base register |
| index_val | input | 32 | Contents of the index register |
| imm_offset | input | 16 | Signed immediate displacement |
| addr_mode | input | 1 | 0 = base plus immediate, 1 = base plus index |
| len_code | input | 2 | Operand length code, length = 1 << code bytes |
| little_endian | input | 1 | 1 for a little-endian access |
| str_mult | input | 1 | 1 for a string/multiple transfer |
| ea | output | 32 | Effective address |
| byte_addr | output | 256 | Eight 32-bit byte-lane addresses, lane 0 in the low bits |
| byte_valid | output | 8 | One bit per byte lane in use |
| wrap | output | 1 | Operand crosses from the top address to 0 |
| align_exc | output | 1 | Word-boundary alignment exception |

## Verification
Wraparound and the alignment exception can both occur on one access. An 8-byte or 4-byte operand at an address such as 0xFFFFFFFE or 0xFFFFFFFD is misaligned and also runs past the top of the space. The sweep reaches these cases by combining base values near 0xFFFFFFFF with small positive and negative offsets, under every length, byte order and string/multiple setting. In each such cycle the bench checks `wrap`, `align_exc` and every byte lane separately against a 33-bit reference. This shows that neither flag masks or distorts the other.

// File: rtl/eag_pkg.sv
package eag_pkg;
    localparam int unsigned EAG_ADDR_W    = 32;
    localparam int unsigned EAG_IMM_W     = 16;
    localparam int unsigned EAG_MAX_BYTES = 8;
    localparam int unsigned EAG_REGSEL_W  = 5;

    typedef enum logic {
        EAG_MODE_IMM = 1'b0,
        EAG_MODE_IDX = 1'b1
    } eag_mode_e;
endpackage

// File: rtl/eag_addend.sv
module eag_addend #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned IMM_W   = 16,
    parameter int unsigned REGSEL_W = 5
) (
    input  logic [REGSEL_W-1:0] base_idx,
    input  logic [ADDR_W-1:0]   base_val,
    input  logic [ADDR_W-1:0]   index_val,
    input  logic [IMM_W-1:0]    imm_offset,
    input  eag_pkg::eag_mode_e  addr_mode,
    output logic [ADDR_W-1:0]   ea
);
    localparam int unsigned EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] base_op;
    logic [ADDR_W-1:0] off_op;
    logic [ADDR_W:0]   sum_full;

    always_comb begin
        base_op = (base_idx == '0) ? '0 : base_val;
        unique case (addr_mode)
            eag_pkg::EAG_MODE_IMM: off_op = {{EXT_W{imm_offset[IMM_W-1]}}, imm_offset};
            eag_pkg::EAG_MODE_IDX: off_op = index_val;
            default:               off_op = '0;
        endcase
        // carry out of the top bit is discarded (R4)
        sum_full = {1'b0, base_op} + {1'b0, off_op};
        ea       = sum_full[ADDR_W-1:0];
    end

    always_comb begin
        if (base_idx == '0 && addr_mode == eag_pkg::EAG_MODE_IDX) begin
            p_zero_base_r3: assert (ea == index_val)
                else $error("zero base did not pass index through");
        end
    end
endmodule

// File: rtl/eag_byte_map.sv
module eag_byte_map #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned MAX_BYTES = 8,
    parameter int unsigned LENC_W    = 2
) (
    input  logic [ADDR_W-1:0]           ea,
    input  logic [LENC_W-1:0]           len_code,
    output logic [MAX_BYTES*ADDR_W-1:0] byte_addr,
    output logic [MAX_BYTES-1:0]        byte_valid,
    output logic                        wrap
);
    logic [ADDR_W-1:0] n_bytes;
    logic [ADDR_W-1:0] last_addr;

    assign n_bytes   = ADDR_W'(1) << len_code;
    assign last_addr = ea + n_bytes - ADDR_W'(1);
    assign wrap      = (last_addr < ea);

    for (genvar i = 0; i < MAX_BYTES; i++) begin : g_lane
        logic in_use;
        assign in_use        = (ADDR_W'(i) < n_bytes);
        assign byte_valid[i] = in_use;
        assign byte_addr[i*ADDR_W +: ADDR_W] = in_use ? (ea + ADDR_W'(i)) : '0;
    end

    always_comb begin
        p_lane0_r6: assert (byte_valid[0] && byte_addr[ADDR_W-1:0] == ea)
            else $error("lane 0 does not carry ea");
        if (wrap) begin
            p_wrap_len_r7: assert (len_code != '0)
                else $error("single byte cannot wrap");
        end
    end
endmodule

// File: rtl/eag_align.sv
module eag_align #(
    parameter int unsigned LENC_W = 2
) (
    input  logic [1:0]        ea_low,
    input  logic [LENC_W-1:0] len_code,
    input  logic              little_endian,
    input  logic              str_mult,
    output logic              align_exc
);
    logic word_or_more;
    logic off_word;
    logic exempt;

    always_comb begin
        word_or_more = (len_code >= LENC_W'(2));
        off_word     = (ea_low != 2'b00);
        exempt       = little_endian & str_mult;
        align_exc    = word_or_more & off_word & ~exempt;
    end

    always_comb begin
        if (!word_or_more) begin
            p_small_no_exc_r8: assert (!align_exc)
                else $error("short operand flagged");
        end
    end
endmodule

// File: rtl/eag_top.sv
module eag_top #(
    parameter int unsigned ADDR_W    = eag_pkg::EAG_ADDR_W,
    parameter int unsigned IMM_W     = eag_pkg::EAG_IMM_W,
    parameter int unsigned MAX_BYTES = eag_pkg::EAG_MAX_BYTES,
    parameter int unsigned REGSEL_W  = eag_pkg::EAG_REGSEL_W,
    localparam int unsigned LENC_W   = $clog2($clog2(MAX_BYTES) + 1)
) (
    input  logic [REGSEL_W-1:0]         base_idx,
    input  logic [ADDR_W-1:0]           base_val,
    input  logic [ADDR_W-1:0]           index_val,
    input  logic [IMM_W-1:0]            imm_offset,
    input  logic                        addr_mode,
    input  logic [LENC_W-1:0]           len_code,
    input  logic                        little_endian,
    input  logic                        str_mult,
    output logic [ADDR_W-1:0]           ea,
    output logic [MAX_BYTES*ADDR_W-1:0] byte_addr,
    output logic [MAX_BYTES-1:0]        byte_valid,
    output logic                        wrap,
    output logic                        align_exc
);
    eag_pkg::eag_mode_e mode_e;
    assign mode_e = eag_pkg::eag_mode_e'(addr_mode);

    eag_addend #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .REGSEL_W(REGSEL_W)) u_addend (
        .base_idx   (base_idx),
        .base_val   (base_val),
        .index_val  (index_val),
        .imm_offset (imm_offset),
        .addr_mode  (mode_e),
        .ea         (ea)
    );

    eag_byte_map #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES), .LENC_W(LENC_W)) u_map (
        .ea         (ea),
        .len_code   (len_code),
        .byte_addr  (byte_addr),
        .byte_valid (byte_valid),
        .wrap       (wrap)
    );

    eag_align #(.LENC_W(LENC_W)) u_align (
        .ea_low        (ea[1:0]),
        .len_code      (len_code),
        .little_endian (little_endian),
        .str_mult      (str_mult),
        .align_exc     (align_exc)
    );

    always_comb begin
        if (align_exc) begin
            p_exc_misaligned_r9: assert (ea[1:0] != 2'b00 && !(little_endian && str_mult))
                else $error("exception on aligned or exempt access");
        end
        if (little_endian && str_mult) begin
            p_strmult_exempt_r10: assert (!align_exc)
                else $error("exempt transfer flagged");
        end
    end
endmodule

// File: tb/eag_top_tb.sv
module eag_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [4:0]   base_idx;
    logic [31:0]  base_val, index_val;
    logic [15:0]  imm_offset;
    logic         addr_mode;
    logic [1:0]   len_code;
    logic         little_endian, str_mult;
    logic [31:0]  ea;
    logic [255:0] byte_addr;
    logic [7:0]   byte_valid;
    logic         wrap, align_exc;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    eag_top u_dut (
        .base_idx(base_idx), .base_val(base_val), .index_val(index_val),
        .imm_offset(imm_offset), .addr_mode(addr_mode), .len_code(len_code),
        .little_endian(little_endian), .str_mult(str_mult), .ea(ea),
        .byte_addr(byte_addr), .byte_valid(byte_valid), .wrap(wrap), .align_exc(align_exc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vec(input logic [4:0] bi, input logic [31:0] bv, input logic [31:0] iv,
                           input logic [15:0] im, input logic md, input logic [1:0] lc,
                           input logic le, input logic sm);
        logic [31:0] base, off, e_ea, e_lane;
        logic [32:0] sum33, last33;
        int nb;
        logic e_exc;
        @(negedge clk);
        base_idx = bi; base_val = bv; index_val = iv; imm_offset = im;
        addr_mode = md; len_code = lc; little_endian = le; str_mult = sm;
        #1;
        base  = (bi == 5'd0) ? 32'd0 : bv;
        off   = md ? iv : {{16{im[15]}}, im};
        sum33 = {1'b0, base} + {1'b0, off};
        e_ea  = sum33[31:0];
        // R5: sampled 1 ns after the inputs change, no clock edge in between
        if (bi == 5'd0)      chk("R3", ea, e_ea);
        else if (sum33[32])  chk("R4", ea, e_ea);
        else if (md)         chk("R2", ea, e_ea);
        else                 chk("R1", ea, e_ea);
        nb = 1 << lc;
        for (int i = 0; i < 8; i++) begin
            e_lane = (i < nb) ? e_ea + 32'(i) : 32'd0;
            chk("R6 lane", byte_addr[i*32 +: 32], e_lane);
            chk("R6 valid", {31'd0, byte_valid[i]}, {31'd0, (i < nb)});
        end
        last33 = {1'b0, e_ea} + 33'(nb - 1);
        chk("R7", {31'd0, wrap}, {31'd0, last33[32]});
        e_exc = (lc >= 2'd2) && (e_ea[1:0] != 2'b00) && !(le && sm);
        if (le && sm)  chk("R10", {31'd0, align_exc}, 32'd0);
        else if (le)   chk("R9", {31'd0, align_exc}, {31'd0, e_exc});
        else           chk("R8", {31'd0, align_exc}, {31'd0, e_exc});
    endtask

    logic [31:0] bases [6] = '{32'h0000_0000, 32'h0000_0003, 32'h7FFF_FFFE,
                              32'hFFFF_FFF9, 32'hFFFF_FFFE, 32'hFFFF_FFFF};
    logic [15:0] imms  [6] = '{16'h0000, 16'h0001, 16'h0006, 16'h7FFF, 16'hFFFF, 16'h8000};

    initial begin
        base_idx = '0; base_val = '0; index_val = '0; imm_offset = '0;
        addr_mode = 1'b0; len_code = '0; little_endian = 1'b0; str_mult = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 idle", ea, 32'd0);
        chk("R6 idle", {24'd0, byte_valid}, 32'h1);
        chk("R7 idle", {31'd0, wrap}, 32'd0);
        for (int b = 0; b < 6; b++)
            for (int o = 0; o < 6; o++)
                for (int l = 0; l < 4; l++)
                    for (int f = 0; f < 8; f++) begin
                        run_vec((f[2] ? 5'd7 : 5'd0), bases[b], bases[o] ^ 32'h0000_0004,
                                imms[o], f[0], 2'(l), f[1], f[2] ^ f[0]);
                        run_vec(5'd31, bases[b], {16'd0, imms[o]}, imms[o], f[0], 2'(l), f[1], f[2]);
                    end
        // R3: base_val must have no effect when base_idx is 0
        run_vec(5'd0, 32'hDEAD_BEEF, 32'h0000_0010, 16'h0010, 1'b1, 2'd2, 1'b0, 1'b0);
        chk("R3 ignore", ea, 32'h0000_0010);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule